// File: doc/BRIEF.md
# Four-Bit Binary Rate Multiplier

This block thins a clock into a sparser train of single-cycle enable pulses. A free-running binary counter steps once per clock. Each bit of a 4-bit rate word owns a fixed, disjoint set of counter states. Across any 16 consecutive clocks the output is high in exactly as many cycles as the value of the rate word. The mean output rate is therefore the clock rate times N/16, and the pulses are spread across the cycle rather than bunched together.

The output is an enable that is high for one cycle at a time. It is not a gated clock, so downstream logic stays in the same clock domain. Several controls let units be chained into wider rate words:
- A synchronous clear and a synchronous preset-to-top place the counter.
- An inhibit input freezes the counter and silences the slot pulses.
- A strobe input blanks the output.
- A cascade input forces the output high, so a less significant unit can fill the gaps.
- A carry output and an active-low terminal-count flag mark the top state.

Top module: `binRateMul`

## Requirements
- R1: The counter leaves reset asynchronous-low reset (rstN=0) at 0. With no clear, preset or inhibit, it rises by one per rising clock edge and wraps from 15 to 0.
- R2: Counter bit 0 is the least significant. Rate-word bit 3 enables the states with count[0]=0. Bit 2 enables the states with count[1:0]=01. Bit 1 enables the states with count[2:0]=011. Bit 0 enables the single state count=0111.
- R3: When several rate bits are set, rateOut is the OR of their slots. Over any 16 consecutive free-running clocks, rateOut is high in exactly rateWord cycles.
- R4: In count state 15, no rate bit produces a pulse.
- R5: clearIn high at a rising edge loads 0. Clear takes priority over preset and inhibit.
- R6: presetIn high at a rising edge (without clear) loads 15. Preset takes priority over inhibit.
- R7: termCountN is low exactly while the count is 15.
- R8: inhibitIn high at an edge (without clear or preset) holds the count. While inhibitIn is high, slot pulses are suppressed.
- R9: carryOut is high while the count is 15 or inhibitIn is high.
- R10: strobeIn high forces rateOut low and rateOutN high, overriding every other input.
- R11: cascadeIn high (without strobe) forces rateOut high, including while inhibited.
- R12: rateOutN is always the complement of rateOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearIn | input | 1 | Synchronous load of 0 |
| presetIn | input | 1 | Synchronous load of 15 |
| strobeIn | input | 1 | Blanks the rate output |
| inhibitIn | input | 1 | Holds the counter, silences slots |
| cascadeIn | input | 1 | Forces the rate output high |
| rateWord | input | 4 | Pulses per 16 clocks |
| rateOut | output | 1 | One-cycle rate enable |
| rateOutN | output | 1 | Complement of rateOut |
| carryOut | output | 1 | Top state or inhibit-in |
| termCountN | output | 1 | Low while count is 15 |

## Verification
A wrong count value shows at the ports within one cycle whenever the rate word exercises the slot belonging to that state. The carry and terminal-count outputs expose an error at the top state within at most 16 clocks. A wrong decode breaks the pulse total over a 16-cycle window, so each single-bit word is run for a full cycle and its pulse positions are compared against a behavioural counter every clock. Priority errors among clear, preset, inhibit, strobe and cascade appear on the very next cycle's outputs.

// File: rtl/brm_pkg.sv
package brm_pkg;
  typedef struct packed {
    logic clearCnt;
    logic presetCnt;
    logic holdCnt;
    logic forceOff;
    logic forceOn;
    logic blockSlots;
  } brmCtl_t;
endpackage

// File: rtl/brmControl.sv
module brmControl
  import brm_pkg::*;
(
  input  logic    clearIn,
  input  logic    presetIn,
  input  logic    inhibitIn,
  input  logic    strobeIn,
  input  logic    cascadeIn,
  output brmCtl_t ctl
);
  always_comb begin
    ctl.clearCnt   = clearIn;
    ctl.presetCnt  = presetIn & ~clearIn;
    ctl.holdCnt    = inhibitIn & ~clearIn & ~presetIn;
    ctl.forceOff   = strobeIn;
    ctl.forceOn    = cascadeIn & ~strobeIn;
    ctl.blockSlots = inhibitIn;
  end
endmodule

// File: rtl/brmDatapath.sv
module brmDatapath
  import brm_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  brmCtl_t      ctl,
  input  logic [W-1:0] rateWord,
  output logic         rateOut,
  output logic         rateOutN,
  output logic         carryOut,
  output logic         termCountN
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] count;
  logic [W-1:0] slotHit;
  logic         atTop;
  logic         gated;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (ctl.clearCnt)  count <= '0;
    else if (ctl.presetCnt) count <= TOP;
    else if (!ctl.holdCnt)  count <= count + 1'b1;
  end

  // Slot j: the j low bits are all ones and bit j is zero; it belongs to rate bit W-1-j.
  for (genvar j = 0; j < W; j++) begin : g_slot
    if (j == 0) begin : g_first
      assign slotHit[j] = ~count[0] & rateWord[W-1];
    end else begin : g_rest
      assign slotHit[j] = (&count[j-1:0]) & ~count[j] & rateWord[W-1-j];
    end
  end

  assign atTop      = (count == TOP);
  assign gated      = (|slotHit) & ~ctl.blockSlots;
  assign rateOut    = ~ctl.forceOff & (ctl.forceOn | gated);
  assign rateOutN   = ~rateOut;
  assign carryOut   = atTop | ctl.blockSlots;
  assign termCountN = ~atTop;

  // R1
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.clearCnt || ctl.presetCnt || ctl.holdCnt) |=> count == W'($past(count) + 1'b1));
  // R2
  slot_excl_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(slotHit));
  // R4
  top_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (termCountN == 1'b0 && !ctl.forceOn) |-> !rateOut);
  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rstN) ctl.clearCnt |=> count == '0);
  // R6
  preset_top_chk: assert property (@(posedge clk) disable iff (!rstN) ctl.presetCnt |=> !termCountN);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN) ctl.holdCnt |=> $stable(count));
  // R10
  strobe_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.forceOff |-> (!rateOut && rateOutN));
endmodule

// File: rtl/binRateMul.sv
module binRateMul
  import brm_pkg::*;
#(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearIn,
  input  logic              presetIn,
  input  logic              strobeIn,
  input  logic              inhibitIn,
  input  logic              cascadeIn,
  input  logic [RATE_W-1:0] rateWord,
  output logic              rateOut,
  output logic              rateOutN,
  output logic              carryOut,
  output logic              termCountN
);
  brmCtl_t ctl;

  brmControl ctrl_i (
    .clearIn  (clearIn),
    .presetIn (presetIn),
    .inhibitIn(inhibitIn),
    .strobeIn (strobeIn),
    .cascadeIn(cascadeIn),
    .ctl      (ctl)
  );

  brmDatapath #(.W(RATE_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .rateWord  (rateWord),
    .rateOut   (rateOut),
    .rateOutN  (rateOutN),
    .carryOut  (carryOut),
    .termCountN(termCountN)
  );

  // R12
  compl_chk: assert property (@(posedge clk) disable iff (!rstN) rateOut != rateOutN);
  // R11
  cascade_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cascadeIn && !strobeIn) |-> rateOut);
  // R9
  carry_inh_chk: assert property (@(posedge clk) disable iff (!rstN) inhibitIn |-> carryOut);
endmodule

// File: tb/binRateMul_tb_top.sv
module binRateMul_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic clearIn = 0, presetIn = 0, strobeIn = 0, inhibitIn = 0, cascadeIn = 0;
  logic [3:0] rateWord = 4'd0;
  logic rateOut, rateOutN, carryOut, termCountN;

  int checks = 0, fails = 0, mCount = 0, pulses = 0;
  bit done = 0;

  binRateMul dut_i (.clk(clk), .rstN(rstN), .clearIn(clearIn), .presetIn(presetIn),
    .strobeIn(strobeIn), .inhibitIn(inhibitIn), .cascadeIn(cascadeIn),
    .rateWord(rateWord), .rateOut(rateOut), .rateOutN(rateOutN),
    .carryOut(carryOut), .termCountN(termCountN));

  always #10 clk = ~clk;

  function automatic bit slotOn(int c, logic [3:0] w);
    int t = 0;
    while (t < 4 && ((c >> t) & 1) == 1) t++;
    if (t >= 4) return 1'b0;
    return w[3-t];
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (count %0d)", tag, what, act, exp, mCount);
    end
  endtask

  task automatic cycle(string tag);
    logic eOut;
    #1;
    if (strobeIn) eOut = 1'b0;
    else if (cascadeIn) eOut = 1'b1;
    else if (inhibitIn) eOut = 1'b0;
    else eOut = slotOn(mCount, rateWord);
    check((mCount == 15) ? "R4" : tag, rateOut, eOut, "rateOut");
    check("R12", rateOutN, ~eOut, "rateOutN");
    check("R7", termCountN, (mCount != 15), "termCountN");
    check("R9", carryOut, (mCount == 15) || inhibitIn, "carryOut");
    if (rateOut === 1'b1) pulses++;
    @(posedge clk);
    if (clearIn) mCount = 0;
    else if (presetIn) mCount = 15;
    else if (!inhibitIn) mCount = (mCount + 1) % 16;
    @(negedge clk);
  endtask

  task automatic window(logic [3:0] w, string tag);
    rateWord = w;
    pulses = 0;
    repeat (16) cycle(tag);
    check(tag, (pulses == int'(w)), 1'b1, "pulse total per 16 clocks");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", termCountN, 1'b1, "termCountN in reset");
    check("R1", rateOut, 1'b0, "rateOut in reset");
    rstN = 1'b1;
    mCount = 0;
    // R1: free-running count and wrap
    repeat (20) cycle("R1");
    // R2: each single bit on its own slot set
    window(4'd1, "R2");
    window(4'd2, "R2");
    window(4'd4, "R2");
    window(4'd8, "R2");
    // R3: combined words
    window(4'd5, "R3");
    window(4'd11, "R3");
    window(4'd15, "R3");
    window(4'd0, "R3");
    rateWord = 4'd15;
    // R5: clear mid-run, and clear with preset and inhibit together
    repeat (5) cycle("R5");
    clearIn = 1; cycle("R5"); clearIn = 0;
    cycle("R5");
    presetIn = 1; clearIn = 1; inhibitIn = 1; cycle("R5");
    presetIn = 0; clearIn = 0; inhibitIn = 0;
    cycle("R5");
    // R6: preset to top, also beating inhibit
    presetIn = 1; inhibitIn = 1; cycle("R6"); presetIn = 0; inhibitIn = 0;
    cycle("R6");
    cycle("R6");
    // R8: inhibit holds count and silences slots
    repeat (2) cycle("R8");
    inhibitIn = 1; repeat (4) cycle("R8"); inhibitIn = 0;
    repeat (3) cycle("R8");
    // R10: strobe beats cascade and slots
    strobeIn = 1; cascadeIn = 1; repeat (4) cycle("R10");
    cascadeIn = 0; repeat (4) cycle("R10"); strobeIn = 0;
    // R11: cascade forces high even while inhibited or with word 0
    rateWord = 4'd0;
    cascadeIn = 1; repeat (3) cycle("R11");
    inhibitIn = 1; repeat (3) cycle("R11");
    inhibitIn = 0; cascadeIn = 0;
    repeat (18) cycle("R11");
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end
endmodule